// File: doc/BRIEF.md
# Decode-Stage Hazard Stall Controller

This block finds read-after-write conflicts in a five-stage in-order pipeline that has no operand forwarding. The stages are fetch, decode, execute, memory access and write-back. While an instruction sits in decode, the block compares each source register the instruction actually reads against the destination of the instruction in execute. It counts a comparison only when the execute instruction writes its destination and that destination is not register 0. When a comparison matches, the block holds the program counter and the fetch-to-decode register for one cycle. In that same cycle it loads a no-operation bubble into the decode-to-execute register. In a bubble the valid bit and every write and memory enable are low.

A thin set of pipeline registers is wrapped around the detector so that instruction timelines can be seen at the ports. The fetch side is an instruction source that responds combinationally to `pc_o`. Each fetched instruction carries an identifying tag, its two source fields with use flags, its destination, its register-write flag and a store flag. The tags of the instructions in execute and in write-back are brought out. Because the producer leaves execute after one cycle, every dependent pair costs exactly one bubble.

Top module: `hz_stall_ctrl`

## Requirements
- R1: A stall is raised when the valid decode instruction has a used source field equal to the execute destination, that destination is nonzero, and the execute register-write flag is high. In that same cycle `ifid_hold_o` and `idex_bubble_o` are 1 and `pc_we_o` is 0.
- R2: A source field whose use flag is 0 never causes a stall, even when its value equals the execute destination.
- R3: An execute instruction with its register-write flag at 0 never causes a stall.
- R4: An execute destination of register 0 never causes a stall.
- R5: `pc_we_o` is always the inverse of the stall. After a stall cycle, `pc_o` keeps the value it had in that cycle.
- R6: During a stall the fetch-to-decode register keeps its instruction. The held instruction enters execute in the cycle after the bubble, and the next sequential instruction enters execute one cycle after that.
- R7: In the cycle after a stall, the execute stage holds a bubble: `ex_valid_o`, `ex_reg_we_o` and `ex_mem_wr_o` are all 0.
- R8: A consumer directly behind its producer receives exactly one bubble, so its tag appears in execute two cycles after the producer's tag. The stall is never high on two consecutive cycles. In a chain of dependent instructions, each link adds one bubble.
- R9: With no hazard, `pc_o` advances by `STEP` on every cycle and instructions enter execute on consecutive cycles in program order.
- R10: A synchronous active-high reset sets `pc_o` to 0 and turns every pipeline register into a bubble, so that `ex_valid_o` and `wb_valid_o` are 0 and no stall is raised.
- R11: Each instruction appears in write-back exactly two cycles after it appears in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| f_tag_i | input | TAG_W | Identifier of the fetched instruction |
| f_rs1_i | input | AW | First source register field |
| f_rs1_use_i | input | 1 | First source is read |
| f_rs2_i | input | AW | Second source register field |
| f_rs2_use_i | input | 1 | Second source is read |
| f_rd_i | input | AW | Destination register field |
| f_reg_we_i | input | 1 | Instruction writes its destination |
| f_mem_wr_i | input | 1 | Instruction stores to memory |
| pc_o | output | PC_W | Program counter (fetch address) |
| pc_we_o | output | 1 | Program counter update enable |
| ifid_hold_o | output | 1 | Fetch-to-decode register hold |
| idex_bubble_o | output | 1 | Bubble insert into decode-to-execute register |
| ex_valid_o | output | 1 | Execute stage holds a real instruction |
| ex_tag_o | output | TAG_W | Tag of the execute instruction |
| ex_reg_we_o | output | 1 | Register-write flag in execute |
| ex_mem_wr_o | output | 1 | Store flag in execute |
| wb_valid_o | output | 1 | Write-back stage holds a real instruction |
| wb_tag_o | output | TAG_W | Tag of the write-back instruction |

## Verification
The bench uses the default parameters: 5-bit register fields, a 32-bit program counter stepping by 4, and 8-bit tags. With these values every register from 0 to 31 can be reached, so both the zero register and the top register 31 are tried as hazard destinations. The 8-bit tags let the bench follow each instruction's arrival in execute and write-back, which it uses to measure bubble counts as gaps in cycles. A 16-entry instruction table is addressed by PC bits 5:2; this covers independent streams, single dependent pairs on either source, unused-source and no-write cases, and a three-instruction dependency chain.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Control bits carried with an instruction down the pipeline.
    typedef struct packed {
        logic valid;
        logic reg_we;
        logic mem_wr;
    } ctl_t;

    // A bubble has no valid bit and no side effects.
    localparam ctl_t CTL_BUBBLE = '{valid: 1'b0, reg_we: 1'b0, mem_wr: 1'b0};

endpackage

// File: rtl/hz_detect.sv
module hz_detect #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic              dec_valid_i,
    input  logic [NSRC*AW-1:0] src_i,
    input  logic [NSRC-1:0]   use_i,
    input  logic [AW-1:0]     ex_rd_i,
    input  logic              ex_we_i,
    output logic              stall_o
);

    logic [NSRC-1:0] hit;
    logic            ex_live;

    // Only a nonzero, actually written destination can conflict.
    assign ex_live = ex_we_i && (ex_rd_i != '0);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = use_i[i] && (src_i[i*AW +: AW] == ex_rd_i);
    end

    assign stall_o = dec_valid_i && ex_live && (|hit);

endmodule

// File: rtl/hz_pc_reg.sv
module hz_pc_reg #(
    parameter int PC_W = 32,
    parameter int STEP = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            we_i,
    output logic [PC_W-1:0] pc_o
);

    localparam logic [PC_W-1:0] INC = PC_W'(STEP);

    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] pc_q;

    always_comb begin
        pc_d = pc_q;
        if (we_i) begin
            pc_d = pc_q + INC;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_o = pc_q;

    // R5: a frozen cycle leaves the fetch address unchanged.
    a_r5_pc_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> $stable(pc_q));

    // R9: an enabled cycle moves to the next sequential address.
    a_r9_pc_step: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> (pc_q == $past(pc_q) + INC));

endmodule

// File: rtl/hz_pipe_regs.sv
module hz_pipe_regs
    import hz_pkg::*;
#(
    parameter int AW    = 5,
    parameter int TAG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             stall_i,
    input  logic [TAG_W-1:0] f_tag_i,
    input  logic [AW-1:0]    f_rs1_i,
    input  logic             f_rs1_use_i,
    input  logic [AW-1:0]    f_rs2_i,
    input  logic             f_rs2_use_i,
    input  logic [AW-1:0]    f_rd_i,
    input  logic             f_reg_we_i,
    input  logic             f_mem_wr_i,
    output logic             d_valid_o,
    output logic [AW-1:0]    d_rs1_o,
    output logic             d_rs1_use_o,
    output logic [AW-1:0]    d_rs2_o,
    output logic             d_rs2_use_o,
    output logic [TAG_W-1:0] x_tag_o,
    output logic [AW-1:0]    x_rd_o,
    output ctl_t             x_ctl_o,
    output logic             w_valid_o,
    output logic [TAG_W-1:0] w_tag_o
);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [AW-1:0]    rs1;
        logic             rs1_use;
        logic [AW-1:0]    rs2;
        logic             rs2_use;
        logic [AW-1:0]    rd;
        ctl_t             ctl;
    } dec_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [AW-1:0]    rd;
        ctl_t             ctl;
    } exe_t;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
    } trk_t;

    typedef struct packed {
        dec_t ifid;
        exe_t idex;
        trk_t exmem;
        trk_t memwb;
    } pipe_t;

    // All-zero state is a bubble in every stage.
    localparam pipe_t PIPE_RST = '0;

    pipe_t st_d;
    pipe_t st_q;

    always_comb begin
        st_d = st_q;

        // Fetch-to-decode: load unless frozen.
        if (!stall_i) begin
            st_d.ifid.tag        = f_tag_i;
            st_d.ifid.rs1        = f_rs1_i;
            st_d.ifid.rs1_use    = f_rs1_use_i;
            st_d.ifid.rs2        = f_rs2_i;
            st_d.ifid.rs2_use    = f_rs2_use_i;
            st_d.ifid.rd         = f_rd_i;
            st_d.ifid.ctl.valid  = 1'b1;
            st_d.ifid.ctl.reg_we = f_reg_we_i;
            st_d.ifid.ctl.mem_wr = f_mem_wr_i;
        end

        // Decode-to-execute: a NOP on a stall, else the decoded instruction.
        if (stall_i) begin
            st_d.idex.tag = '0;
            st_d.idex.rd  = '0;
            st_d.idex.ctl = CTL_BUBBLE;
        end else begin
            st_d.idex.tag = st_q.ifid.tag;
            st_d.idex.rd  = st_q.ifid.rd;
            st_d.idex.ctl = st_q.ifid.ctl;
        end

        // Memory and write-back stages simply advance.
        st_d.exmem.valid = st_q.idex.ctl.valid;
        st_d.exmem.tag   = st_q.idex.tag;
        st_d.memwb       = st_q.exmem;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= PIPE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign d_valid_o   = st_q.ifid.ctl.valid;
    assign d_rs1_o     = st_q.ifid.rs1;
    assign d_rs1_use_o = st_q.ifid.rs1_use;
    assign d_rs2_o     = st_q.ifid.rs2;
    assign d_rs2_use_o = st_q.ifid.rs2_use;
    assign x_tag_o     = st_q.idex.tag;
    assign x_rd_o      = st_q.idex.rd;
    assign x_ctl_o     = st_q.idex.ctl;
    assign w_valid_o   = st_q.memwb.valid;
    assign w_tag_o     = st_q.memwb.tag;

    // R6: the decode instruction survives a frozen cycle unchanged.
    a_r6_ifid_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_i |=> ($stable(st_q.ifid.tag) && st_q.ifid.ctl.valid));

    // R7: the execute stage sees a side-effect-free NOP after a stall.
    a_r7_bubble: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_i |=> (!st_q.idex.ctl.valid && !st_q.idex.ctl.reg_we && !st_q.idex.ctl.mem_wr));

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int AW    = 5,
    parameter int PC_W  = 32,
    parameter int TAG_W = 8,
    parameter int STEP  = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [TAG_W-1:0] f_tag_i,
    input  logic [AW-1:0]    f_rs1_i,
    input  logic             f_rs1_use_i,
    input  logic [AW-1:0]    f_rs2_i,
    input  logic             f_rs2_use_i,
    input  logic [AW-1:0]    f_rd_i,
    input  logic             f_reg_we_i,
    input  logic             f_mem_wr_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             pc_we_o,
    output logic             ifid_hold_o,
    output logic             idex_bubble_o,
    output logic             ex_valid_o,
    output logic [TAG_W-1:0] ex_tag_o,
    output logic             ex_reg_we_o,
    output logic             ex_mem_wr_o,
    output logic             wb_valid_o,
    output logic [TAG_W-1:0] wb_tag_o
);

    localparam int NSRC = 2;

    logic          stall;
    logic          d_valid;
    logic [AW-1:0] d_rs1;
    logic          d_rs1_use;
    logic [AW-1:0] d_rs2;
    logic          d_rs2_use;
    logic [AW-1:0] x_rd;
    ctl_t          x_ctl;

    hz_pipe_regs #(.AW(AW), .TAG_W(TAG_W)) u_pipe (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .stall_i     (stall),
        .f_tag_i     (f_tag_i),
        .f_rs1_i     (f_rs1_i),
        .f_rs1_use_i (f_rs1_use_i),
        .f_rs2_i     (f_rs2_i),
        .f_rs2_use_i (f_rs2_use_i),
        .f_rd_i      (f_rd_i),
        .f_reg_we_i  (f_reg_we_i),
        .f_mem_wr_i  (f_mem_wr_i),
        .d_valid_o   (d_valid),
        .d_rs1_o     (d_rs1),
        .d_rs1_use_o (d_rs1_use),
        .d_rs2_o     (d_rs2),
        .d_rs2_use_o (d_rs2_use),
        .x_tag_o     (ex_tag_o),
        .x_rd_o      (x_rd),
        .x_ctl_o     (x_ctl),
        .w_valid_o   (wb_valid_o),
        .w_tag_o     (wb_tag_o)
    );

    hz_detect #(.AW(AW), .NSRC(NSRC)) u_detect (
        .dec_valid_i (d_valid),
        .src_i       ({d_rs2, d_rs1}),
        .use_i       ({d_rs2_use, d_rs1_use}),
        .ex_rd_i     (x_rd),
        .ex_we_i     (x_ctl.reg_we),
        .stall_o     (stall)
    );

    hz_pc_reg #(.PC_W(PC_W), .STEP(STEP)) u_pc (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .we_i  (pc_we_o),
        .pc_o  (pc_o)
    );

    assign pc_we_o       = !stall;
    assign ifid_hold_o   = stall;
    assign idex_bubble_o = stall;
    assign ex_valid_o    = x_ctl.valid;
    assign ex_reg_we_o   = x_ctl.reg_we;
    assign ex_mem_wr_o   = x_ctl.mem_wr;

    // R4: the hardwired zero register in execute never freezes decode.
    a_r4_zero_dst: assert property (@(posedge clk_i) disable iff (rst_i)
        (x_rd == '0) |-> !stall);

    // R8: the producer leaves execute after one frozen cycle, so one bubble only.
    a_r8_one_bubble: assert property (@(posedge clk_i) disable iff (rst_i)
        stall |=> !stall);

endmodule

// File: tb/test_hz_stall_ctrl.sv
module test_hz_stall_ctrl;

    localparam int AW    = 5;
    localparam int PC_W  = 32;
    localparam int TAG_W = 8;
    localparam int STEP  = 4;

    typedef struct packed {
        logic [7:0] tag;
        logic [4:0] rs1;
        logic       u1;
        logic [4:0] rs2;
        logic       u2;
        logic [4:0] rd;
        logic       we;
        logic       mw;
    } ins_t;

    // Row: producer destination/write, consumer sources/uses, expected bubbles.
    typedef struct packed {
        logic [4:0] rd;
        logic       we;
        logic [4:0] rs1;
        logic       u1;
        logic [4:0] rs2;
        logic       u2;
        logic [1:0] bub;
    } row_t;

    localparam int NROW = 8;
    localparam row_t ROWS [NROW] = '{
        '{5'd5,  1'b1, 5'd5,  1'b1, 5'd0,  1'b0, 2'd1},  // R1 via first source
        '{5'd7,  1'b1, 5'd3,  1'b1, 5'd7,  1'b1, 2'd1},  // R1 via second source
        '{5'd7,  1'b1, 5'd7,  1'b0, 5'd7,  1'b0, 2'd0},  // R2 unused sources
        '{5'd9,  1'b0, 5'd9,  1'b1, 5'd9,  1'b1, 2'd0},  // R3 no write
        '{5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 2'd0},  // R4 zero register
        '{5'd6,  1'b1, 5'd2,  1'b1, 5'd3,  1'b1, 2'd0},  // R9 independent
        '{5'd31, 1'b1, 5'd31, 1'b1, 5'd31, 1'b1, 2'd1},  // R1 both, top register
        '{5'd12, 1'b1, 5'd13, 1'b1, 5'd11, 1'b1, 2'd0}   // R9 near miss
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    ins_t imem [16];
    ins_t cur;

    logic [PC_W-1:0]  pc_o;
    logic             pc_we_o, ifid_hold_o, idex_bubble_o;
    logic             ex_valid_o, ex_reg_we_o, ex_mem_wr_o, wb_valid_o;
    logic [TAG_W-1:0] ex_tag_o, wb_tag_o;

    always_comb begin
        cur = '0;
        cur.tag = 8'hFF;
        if (pc_o[PC_W-1:2] < 16) begin
            cur = imem[pc_o[5:2]];
        end
    end

    hz_stall_ctrl #(.AW(AW), .PC_W(PC_W), .TAG_W(TAG_W), .STEP(STEP)) i_hz_stall_ctrl (
        .clk_i         (clk),
        .rst_i         (rst),
        .f_tag_i       (cur.tag),
        .f_rs1_i       (cur.rs1),
        .f_rs1_use_i   (cur.u1),
        .f_rs2_i       (cur.rs2),
        .f_rs2_use_i   (cur.u2),
        .f_rd_i        (cur.rd),
        .f_reg_we_i    (cur.we),
        .f_mem_wr_i    (cur.mw),
        .pc_o          (pc_o),
        .pc_we_o       (pc_we_o),
        .ifid_hold_o   (ifid_hold_o),
        .idex_bubble_o (idex_bubble_o),
        .ex_valid_o    (ex_valid_o),
        .ex_tag_o      (ex_tag_o),
        .ex_reg_we_o   (ex_reg_we_o),
        .ex_mem_wr_o   (ex_mem_wr_o),
        .wb_valid_o    (wb_valid_o),
        .wb_tag_o      (wb_tag_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    int ex_at [256];
    int wb_at [256];
    int n_stall;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic ins_t mk(input int tag, input int rs1, input int u1, input int rs2,
                                input int u2, input int rd, input int we, input int mw);
        ins_t r;
        r.tag = 8'(tag);
        r.rs1 = 5'(rs1);
        r.u1  = 1'(u1);
        r.rs2 = 5'(rs2);
        r.u2  = 1'(u2);
        r.rd  = 5'(rd);
        r.we  = 1'(we);
        r.mw  = 1'(mw);
        return r;
    endfunction

    task automatic fill_nops();
        for (int i = 0; i < 16; i++) begin
            imem[i] = mk(10 + i, 0, 0, 0, 0, 0, 0, 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs from a negedge right after reset; cycle c is the c-th negedge.
    task automatic run(input int ncyc);
        logic            prev_stall;
        logic [PC_W-1:0] prev_pc;
        for (int i = 0; i < 256; i++) begin
            ex_at[i] = -1;
            wb_at[i] = -1;
        end
        n_stall    = 0;
        prev_stall = 1'b0;
        prev_pc    = pc_o;
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            if (prev_stall) begin
                chk("R5 pc held after stall", pc_o, prev_pc);
                chk("R7 bubble valid", ex_valid_o, 0);
                chk("R7 bubble reg write", ex_reg_we_o, 0);
                chk("R7 bubble store", ex_mem_wr_o, 0);
                chk("R8 no back-to-back stall", idex_bubble_o, 0);
            end
            chk("R5 pc_we inverse of stall", pc_we_o, !idex_bubble_o);
            chk("R1 hold equals bubble", ifid_hold_o, idex_bubble_o);
            if (ex_valid_o && ex_at[ex_tag_o] < 0) ex_at[ex_tag_o] = c;
            if (wb_valid_o && wb_at[wb_tag_o] < 0) wb_at[wb_tag_o] = c;
            if (idex_bubble_o) n_stall++;
            prev_stall = idex_bubble_o;
            prev_pc    = pc_o;
        end
    endtask

    function automatic string row_req(input int r);
        case (r)
            0, 1, 6: return "R1";
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            default: return "R9";
        endcase
    endfunction

    initial begin
        fill_nops();

        // Table walk: producer (tag 1) followed directly by consumer (tag 2).
        for (int r = 0; r < NROW; r++) begin
            fill_nops();
            imem[0] = mk(1, 0, 0, 0, 0, ROWS[r].rd, ROWS[r].we, 0);
            imem[1] = mk(2, ROWS[r].rs1, ROWS[r].u1, ROWS[r].rs2, ROWS[r].u2, 0, 0, 1);
            do_reset();
            run(12);
            chk({row_req(r), " stall count"}, n_stall, ROWS[r].bub);
            chk({row_req(r), " R8 consumer gap"}, ex_at[2] - ex_at[1], 1 + ROWS[r].bub);
            chk("R6 next instruction follows consumer", ex_at[12] - ex_at[2], 1);
            chk("R11 producer reaches write-back", wb_at[1] - ex_at[1], 2);
        end

        // R8 chain: A writes r3, B reads r3 and writes r4, C reads r4.
        fill_nops();
        imem[0] = mk(1, 0, 0, 0, 0, 3, 1, 0);
        imem[1] = mk(2, 3, 1, 0, 0, 4, 1, 0);
        imem[2] = mk(3, 0, 0, 4, 1, 0, 0, 0);
        do_reset();
        run(14);
        chk("R8 chain stall count", n_stall, 2);
        chk("R8 chain first gap", ex_at[2] - ex_at[1], 2);
        chk("R8 chain second gap", ex_at[3] - ex_at[2], 2);
        chk("R11 chain tail write-back", wb_at[3] - ex_at[3], 2);

        // R9: independent writers, reg 0 read on the second source.
        for (int i = 0; i < 16; i++) begin
            imem[i] = mk(10 + i, i + 16, 1, 0, 1, i + 1, 1, 0);
        end
        do_reset();
        for (int c = 1; c <= 10; c++) begin
            @(negedge clk);
            chk("R9 pc advance", pc_o, STEP * c);
            chk("R9 no stall", idex_bubble_o, 0);
            if (c >= 2) chk("R9 execute order", ex_tag_o, 10 + c - 2);
            if (c >= 4) chk("R11 write-back order", wb_tag_o, 10 + c - 4);
        end

        // R10: reset in the middle of a dependent run clears everything.
        fill_nops();
        imem[0] = mk(1, 0, 0, 0, 0, 8, 1, 0);
        imem[1] = mk(2, 8, 1, 0, 0, 9, 1, 0);
        do_reset();
        run(5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 pc cleared", pc_o, 0);
        chk("R10 execute empty", ex_valid_o, 0);
        chk("R10 write-back empty", wb_valid_o, 0);
        chk("R10 no stall", idex_bubble_o, 0);
        chk("R10 pc enabled", pc_we_o, 1);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule